// File: doc/BRIEF.md
# Multiplexed Burst Local Bus Master

This block turns a burst request from a processor core into cycles on a 32-bit local bus where addresses and data share the same wires. The request gives a word address, a direction, a burst length of one to four words and up to four words of write data. The block first runs one address cycle. In that cycle it drives the word address on the upper thirty bus bits and the length code on the two low bits, and it pulls an active-low address strobe. It then runs one data cycle for each word. For a write it drives each word in turn. For a read it releases the bus and captures whatever an external device places on it. When the last word is done, the block raises a completion pulse, and for a read it presents the collected words.

The bus states advance on an internal clock that runs at half the rate of the incoming `clk2`. This internal clock is made with a phase toggle, so every bus state lasts exactly two `clk2` cycles. While the block is idle, a hold request from another master makes it grant the bus and leave all of its outputs floating. Tristating is modelled with separate output-enable signals, which the chip's pad ring turns into real tristate pins. The block accepts a new request only when it is idle and no hold is asked for. A request at any other time is ignored.

Top module: `lbus_burst_master`

## Requirements
- R1: After reset the block is idle: `bus_oe`, `ale_oe`, `hold_ack` and `done` are 0, `ale_n` is 1 and `req_ready` is 1.
- R2: Every bus state (address cycle, each data cycle, the done cycle) lasts exactly two `clk2` cycles. State changes only on every second `clk2` edge.
- R3: In the address cycle `bus_oe`=1, `ale_oe`=1, `ale_n`=0, and `bus_out` = {word address[29:0], size code[1:0]}.
- R4: A size code n (00=1 word, 01=2, 10=3, 11=4) produces exactly n+1 data cycles after the address cycle. During these cycles `ale_oe`=1 and `ale_n`=1.
- R5: In write data cycle k (k from 0), `bus_oe`=1 and `bus_out` = `req_wdata[32k+31:32k]`.
- R6: In read data cycles `bus_oe`=0. `bus_in` is sampled at the end of data cycle k into `rdata[32k+31:32k]`. Words beyond the burst length read as 0.
- R7: `done` is 1 for the internal cycle right after the last data cycle, which is two `clk2` cycles, and is 0 otherwise.
- R8: When the bus is idle, `bus_oe` and `ale_oe` are 0.
- R9: A hold request seen while idle moves the block into hold: `hold_ack`=1, `bus_oe`=`ale_oe`=0, `req_ready`=0. Hold takes priority over a request that arrives at the same time. Dropping the hold request returns the block to idle.
- R10: A hold request raised during a burst does not shorten or interrupt it. The hold is granted right after the done cycle.
- R11: `req_ready` is 0 while a burst or hold is active, and a `req_valid` seen then is ignored: it starts no further address cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 30 | Word address |
| req_size | input | 2 | Burst length code (words minus one) |
| req_wdata | input | 128 | Write words, word k in bits 32k+31:32k |
| req_ready | output | 1 | Request can be accepted now |
| hold_req | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus granted away, outputs floated |
| bus_in | input | 32 | Value seen on the shared bus pins |
| bus_out | output | 32 | Value driven onto the shared bus pins |
| bus_oe | output | 1 | Drive enable for the bus pins |
| ale_n | output | 1 | Active-low address latch strobe |
| ale_oe | output | 1 | Drive enable for the strobe pin |
| done | output | 1 | Burst finished |
| rdata | output | 128 | Collected read words |

## Verification
Bursts of every length are run in both directions, with random addresses and data. The read data depends on both the address and the word index, so a word lost, repeated or stored in the wrong slot can be told apart from a correct capture. Directed cases send a request during a burst and a request together with a hold request. These show whether an ignored request leaks into a later address cycle, and whether hold wins when both arrive in the same cycle. A hold raised in the middle of a burst separates a block that finishes the burst from one that cuts it short.

// File: rtl/lbus_burst_master.sv
module lbus_burst_master #(
  parameter int DW   = 32,
  parameter int MAXW = 4
) (
  input  logic                 clk2,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [DW-3:0]        req_addr,
  input  logic [1:0]           req_size,
  input  logic [MAXW*DW-1:0]   req_wdata,
  output logic                 req_ready,
  input  logic                 hold_req,
  output logic                 hold_ack,
  input  logic [DW-1:0]        bus_in,
  output logic [DW-1:0]        bus_out,
  output logic                 bus_oe,
  output logic                 ale_n,
  output logic                 ale_oe,
  output logic                 done,
  output logic [MAXW*DW-1:0]   rdata
);
  localparam int AW = DW - 2;

  typedef enum logic [1:0] {S_IDLE, S_TA, S_TD, S_HOLD} st_t;

  st_t                st;
  logic               ph;
  logic               wr;
  logic [AW-1:0]      adr;
  logic [1:0]         len;
  logic [1:0]         cnt;
  logic [MAXW*DW-1:0] wbuf;

  wire step = ph;

  assign req_ready = (st == S_IDLE) && !hold_req;
  assign hold_ack  = (st == S_HOLD);
  assign ale_oe    = (st == S_TA) || (st == S_TD);
  assign ale_n     = (st != S_TA);
  assign bus_oe    = (st == S_TA) || ((st == S_TD) && wr);
  assign bus_out   = (st == S_TA) ? {adr, len} :
                     ((st == S_TD) && wr) ? wbuf[cnt*DW +: DW] : '0;

  always_ff @(posedge clk2 or negedge rst_n)
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;

  always_ff @(posedge clk2 or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wr    <= 1'b0;
      adr   <= '0;
      len   <= '0;
      cnt   <= '0;
      wbuf  <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else if (step) begin
      done <= (st == S_TD) && (cnt == len);
      case (st)
        S_IDLE: begin
          if (hold_req) begin
            st <= S_HOLD;
          end else if (req_valid) begin
            st    <= S_TA;
            wr    <= req_write;
            adr   <= req_addr;
            len   <= req_size;
            wbuf  <= req_wdata;
            cnt   <= '0;
            rdata <= '0;
          end
        end
        S_TA: st <= S_TD;
        S_TD: begin
          if (!wr) rdata[cnt*DW +: DW] <= bus_in;
          if (cnt == len) st <= S_IDLE;
          else            cnt <= cnt + 2'd1;
        end
        S_HOLD: if (!hold_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module lbus_burst_master_chk (
  input logic       clk2,
  input logic       rst_n,
  input logic       ph,
  input logic [1:0] st,
  input logic       wr,
  input logic       req_ready,
  input logic       hold_ack,
  input logic       bus_oe,
  input logic       ale_n,
  input logic       ale_oe,
  input logic       done
);
  // R2
  state_hold_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    !ph |=> $stable(st));
  // R3
  addr_drive_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (ale_oe && !ale_n) |-> bus_oe);
  // R6
  read_release_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (ale_oe && ale_n && !wr) |-> !bus_oe);
  // R9
  hold_float_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    hold_ack |-> (!bus_oe && !ale_oe && !req_ready));
  // R11
  busy_block_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (ale_oe || hold_ack) |-> !req_ready);
  // R7
  done_after_data_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    $rose(done) |-> $past(ale_oe && ale_n));
endmodule

bind lbus_burst_master lbus_burst_master_chk chk (
  .clk2(clk2), .rst_n(rst_n), .ph(ph), .st(st), .wr(wr),
  .req_ready(req_ready), .hold_ack(hold_ack), .bus_oe(bus_oe),
  .ale_n(ale_n), .ale_oe(ale_oe), .done(done)
);

// File: tb/lbus_burst_master_test.sv
module lbus_burst_master_test;
  logic         clk2 = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [29:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic [127:0] req_wdata = '0;
  logic         req_ready;
  logic         hold_req = 1'b0;
  logic         hold_ack;
  logic [31:0]  bus_in = '0;
  logic [31:0]  bus_out;
  logic         bus_oe, ale_n, ale_oe, done;
  logic [127:0] rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  lbus_burst_master uut (.*);

  always #10 clk2 = ~clk2;

  function automatic logic [31:0] rd_word(logic [29:0] a, int k);
    return {a[27:0], 4'h0} ^ (32'h9E37_79B9 * (k + 1));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [29:0] a, input logic [1:0] sz, input bit w,
                     input logic [127:0] wd, input bit intrude, input bit hold_mid);
    logic [127:0] exp_rd = '0;
    bit found = 1'b0;
    @(negedge clk2);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    for (int i = 0; i < 10 && !found; i++) begin
      @(negedge clk2);
      found = ale_oe && !ale_n;
    end
    chk(found, "R3 address cycle start", {127'b0, found}, 128'd1);
    if (!found) begin req_valid = 1'b0; return; end
    req_valid = 1'b0;
    req_addr = ~a;
    chk(bus_oe && bus_out == {a, sz}, "R3 address/size on bus", bus_out, {a, sz});
    if (hold_mid) hold_req = 1'b1;
    @(negedge clk2);
    chk(ale_oe && !ale_n && bus_out == {a, sz}, "R2 address cycle second half", {ale_n, bus_out}, {1'b0, a, sz});
    for (int k = 0; k <= sz; k++) begin
      for (int h = 0; h < 2; h++) begin
        @(negedge clk2);
        if (h == 0) begin
          bus_in = rd_word(a, k);
          if (intrude && k == 0) req_valid = 1'b1;
        end
        chk(ale_oe && ale_n && !hold_ack, "R4 data cycle", {ale_oe, ale_n, hold_ack}, 3'b110);
        chk(!req_ready, "R11 ready low when busy", req_ready, 0);
        if (w) chk(bus_oe && bus_out == wd[32*k +: 32], "R5 write word", bus_out, wd[32*k +: 32]);
        else   chk(!bus_oe, "R6 bus released on read", bus_oe, 0);
        if (hold_mid) chk(!hold_ack, "R10 no hold mid burst", hold_ack, 0);
        if (k == sz && h == 1) req_valid = 1'b0;
      end
      exp_rd[32*k +: 32] = rd_word(a, k);
    end
    @(negedge clk2);
    chk(done, "R7 done after last word", done, 1);
    chk(!bus_oe && !ale_oe, "R8 idle float / R4 length", {bus_oe, ale_oe}, 0);
    if (!w) chk(rdata == exp_rd, "R6 read data", rdata, exp_rd);
    @(negedge clk2);
    chk(done, "R7 done held two clk2", done, 1);
    @(negedge clk2);
    chk(!done, "R7 done drops", done, 0);
    if (intrude) chk(!ale_oe, "R11 ignored request left no cycle", ale_oe, 0);
    if (hold_mid) begin
      chk(hold_ack && !bus_oe && !ale_oe, "R10 hold after burst", hold_ack, 1);
      hold_req = 1'b0;
      @(negedge clk2); @(negedge clk2);
      chk(!hold_ack, "R9 hold release", hold_ack, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk2);
    chk(!bus_oe && !ale_oe && ale_n && !hold_ack && !done && req_ready,
        "R1 reset state", {bus_oe, ale_oe, ale_n, hold_ack, done, req_ready}, 6'b001001);
    rst_n = 1'b1;
    @(negedge clk2);
    chk(!bus_oe && !ale_oe && req_ready, "R1 idle after reset", {bus_oe, ale_oe, req_ready}, 3'b001);

    for (int s = 0; s < 4; s++) begin
      txn(30'h0ABC_DEF0 + 30'(s), 2'(s), 1'b1, {32'h1111_0000 + 32'(s), 32'h2222_2222, 32'h3333_3333, 32'h4444_4444}, 1'b0, 1'b0);
      txn(30'h1234_5670 + 30'(s), 2'(s), 1'b0, '0, 1'b0, 1'b0);
    end
    txn(30'h3FFF_FFFF, 2'd3, 1'b0, '0, 1'b1, 1'b0);
    txn(30'h0000_0000, 2'd1, 1'b1, {4{32'hA5A5_5A5A}}, 1'b1, 1'b0);
    txn(30'h2AAA_AAAA, 2'd2, 1'b1, {4{32'hDEAD_BEEF}}, 1'b0, 1'b1);

    @(negedge clk2);
    hold_req = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 30'h155; req_size = 2'd0;
    repeat (4) @(negedge clk2);
    chk(hold_ack && !ale_oe && !bus_oe && !req_ready, "R9 hold wins over request",
        {hold_ack, ale_oe, bus_oe, req_ready}, 4'b1000);
    req_valid = 1'b0;
    @(negedge clk2);
    hold_req = 1'b0;
    repeat (6) begin
      @(negedge clk2);
      chk(!ale_oe, "R11 request during hold ignored", ale_oe, 0);
    end
    chk(!hold_ack && req_ready, "R9 back to idle", {hold_ack, req_ready}, 2'b01);

    for (int i = 0; i < 24; i++) begin
      txn($urandom, 2'($urandom), 1'($urandom), {$urandom, $urandom, $urandom, $urandom}, 1'b0, 1'b0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule